// File: doc/BRIEF.md
# Dual-Path Divider Configuration Interface

This block holds the settings of a clock synthesizer's dividers: a 9-bit feedback-divide value, a 2-bit post-divide code and a 3-bit test-select code. Two routes can write them. On the parallel route, the feedback and post-divide values come from input pins under a level-sensitive load strobe. On the serial route, a 14-bit shift register is clocked from a slow serial clock and data line, and its content is moved into the held values under a second strobe. The dividers themselves are not part of this block.

The serial clock, serial data, both strobes and the parallel value pins are slow board-level signals. All of them pass through a two-stage synchroniser into the single system clock domain, and edges are detected there. Each of these inputs must therefore hold every level for several system clocks. The parallel route takes priority: while its strobe is low, the serial strobe has no effect and the test-select code stays at zero.

Top module: `divcfg_if`

## Requirements
- R1: Reset gives feedback value 9'h1FF, post-divide code 2'b11, test-select 3'b000 and serial output 0.
- R2: The shift register moves by one position toward its MSB, taking in the synchronised data bit, once for each low-to-high change of the synchronised serial clock. It does not move on a falling edge or while the clock is steady.
- R3: The serial output is bit 13 (the MSB) of the shift register, so after 14 shifts it shows the first bit that was sent.
- R4: The shift register maps to the fields as bits 13..11 = test-select, bits 10..9 = post-divide code and bits 8..0 = feedback value. The first bit sent is therefore the test-select MSB, and each field arrives MSB first.
- R5: While the parallel strobe is high and the serial strobe is high, the held values follow the shift register. On the serial strobe's falling edge they keep the last value.
- R6: While the parallel strobe is low, the feedback value and post-divide code follow the parallel pins, and test-select is forced to 3'b000.
- R7: On the parallel strobe's rising edge the last value followed stays held. Later changes on the parallel pins are ignored.
- R8: While the parallel strobe is low, a high serial strobe has no effect on the held values.
- R9: A change on any input pin reaches the outputs on the third rising system clock edge after it was first sampled, and not earlier.
- R10: While the parallel strobe is high and the serial strobe is low, serial shifting and parallel pin changes leave the held values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous, slow) |
| ser_dat_i | input | 1 | Serial data bit |
| ser_ld_i | input | 1 | Serial transfer strobe, active high |
| par_ld_i | input | 1 | Parallel load strobe, follows pins while low |
| par_m_i | input | 9 | Parallel feedback-divide value |
| par_n_i | input | 2 | Parallel post-divide code |
| m_o | output | 9 | Held feedback-divide value |
| n_o | output | 2 | Held post-divide code |
| t_o | output | 3 | Held test-select code |
| ser_q_o | output | 1 | Shift-register MSB |

## Verification
Every input reaches the outputs on the third rising edge after it is first sampled: two synchroniser stages, then the update register. A serial clock edge becomes a shift on that same third edge, because the edge detector compares the second synchroniser stage against a copy one cycle older. The bench model keeps a queue of pin snapshots and acts on the snapshot taken two edges earlier, with the serial clock level from three edges earlier. The model is compared against the outputs at every falling edge. The directed latency check looks at the outputs just after the second and just after the third rising edge that follows a pin change. All other directed checks wait several clocks after stimulus, so that only settled values are compared.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int T_W  = 3;
  localparam int SR_W = T_W + N_W + M_W;

  // field order of the serial word: test-select on top, feedback value at bottom
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam cfg_t CFG_RST = '{t: '0, n: '1, m: '1};

  function automatic logic [SR_W-1:0] sr_push(logic [SR_W-1:0] sr, logic b);
    return {sr[SR_W-2:0], b};
  endfunction

  function automatic cfg_t sr_fields(logic [SR_W-1:0] sr);
    return cfg_t'(sr);
  endfunction

  function automatic cfg_t pins_fields(logic [M_W-1:0] m, logic [N_W-1:0] n);
    return '{t: '0, n: n, m: m};
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg
  import divcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            din,
  output logic [SR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (step) q <= sr_push(q, din);
  end
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold
  import divcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic par_open,
  input  logic ser_open,
  input  cfg_t par_cfg,
  input  cfg_t ser_cfg,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RST;
    else if (par_open) cfg_q <= par_cfg;
    else if (ser_open) cfg_q <= ser_cfg;
  end
endmodule

// File: rtl/divcfg_if.sv
module divcfg_if
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_ld_i,
  input  logic           par_ld_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           ser_q_o
);
  localparam int BUS_W = 4 + M_W + N_W;
  localparam logic [BUS_W-1:0] BUS_RST = {3'b000, 1'b1, {M_W{1'b1}}, {N_W{1'b1}}};

  logic [BUS_W-1:0] raw_bus, sync_bus;
  logic             sclk_s, sdat_s, sld_s, pld_s;
  logic [M_W-1:0]   pm_s;
  logic [N_W-1:0]   pn_s;
  logic             sclk_prev;
  logic [SR_W-1:0]  sh_vec;
  cfg_t             held;

  // named events for the checker
  logic sclk_rise, pl_low, sl_high;

  assign raw_bus = {ser_clk_i, ser_dat_i, ser_ld_i, par_ld_i, par_m_i, par_n_i};

  divcfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {sclk_s, sdat_s, sld_s, pld_s, pm_s, pn_s} = sync_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign pl_low    = ~pld_s;
  assign sl_high   = sld_s;

  divcfg_shreg i_shreg (
    .clk(clk), .rst_n(rst_n), .step(sclk_rise), .din(sdat_s), .q(sh_vec)
  );

  divcfg_hold i_hold (
    .clk(clk), .rst_n(rst_n),
    .par_open(pl_low), .ser_open(sl_high),
    .par_cfg(pins_fields(pm_s, pn_s)), .ser_cfg(sr_fields(sh_vec)),
    .cfg_q(held)
  );

  assign m_o     = held.m;
  assign n_o     = held.n;
  assign t_o     = held.t;
  assign ser_q_o = sh_vec[SR_W-1];
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
  import divcfg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_rise,
  input logic            pl_low,
  input logic            sl_high,
  input logic [SR_W-1:0] sh_vec,
  input logic [M_W-1:0]  m_o,
  input logic [N_W-1:0]  n_o,
  input logic [T_W-1:0]  t_o
);
  // R1
  a_r1_reset_vals: assert property (@(posedge clk)
    !rst_n |=> (m_o == '1 && n_o == '1 && t_o == '0));

  // R2
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sh_vec[SR_W-1:1] == $past(sh_vec[SR_W-2:0]));

  // R2
  a_r2_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sh_vec));

  // R6 and R8
  a_r6_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pl_low |=> t_o == '0);

  // R5
  a_r5_follow_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_low && sl_high) |=> {t_o, n_o, m_o} == $past(sh_vec));

  // R10
  a_r10_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_low && !sl_high) |=> $stable({t_o, n_o, m_o}));
endmodule

bind divcfg_if divcfg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .pl_low(pl_low),
  .sl_high(sl_high), .sh_vec(sh_vec), .m_o(m_o), .n_o(n_o), .t_o(t_o)
);

// File: tb/test_divcfg_if.sv
module test_divcfg_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sc = 1'b0, sd = 1'b0, sl = 1'b0, pl = 1'b1;
  logic [8:0] pm = 9'h1FF;
  logic [1:0] pn = 2'b11;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       ser_q_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  divcfg_if i_divcfg_if (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sc), .ser_dat_i(sd), .ser_ld_i(sl),
    .par_ld_i(pl), .par_m_i(pm), .par_n_i(pn),
    .m_o(m_o), .n_o(n_o), .t_o(t_o), .ser_q_o(ser_q_o)
  );

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic       c, d, s, p;
    logic [8:0] m;
    logic [1:0] n;
  } pins_t;

  localparam pins_t PIN_RST = '{c: 0, d: 0, s: 0, p: 1, m: 9'h1FF, n: 2'b11};

  pins_t       hist[$];
  logic [8:0]  em;
  logic [1:0]  en;
  logic [2:0]  et;
  logic [13:0] esh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em = 9'h1FF; en = 2'b11; et = 3'b000; esh = '0;
      hist = {PIN_RST, PIN_RST, PIN_RST};
    end else begin
      pins_t now_p, seen, older;
      seen  = hist[1];
      older = hist[2];
      if (!seen.p) begin
        em = seen.m; en = seen.n; et = 3'b000;
      end else if (seen.s) begin
        {et, en, em} = esh;
      end
      if (seen.c && !older.c) esh = {esh[12:0], seen.d};
      now_p = '{c: sc, d: sd, s: sl, p: pl, m: pm, n: pn};
      hist.push_front(now_p);
      void'(hist.pop_back());
    end
  end

  // R9: cycle-exact comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if ({m_o, n_o, t_o, ser_q_o} !== {em, en, et, esh[13]}) begin
        mismatched++;
        $display("FAIL R9 per-cycle: got m=%h n=%h t=%h q=%b exp m=%h n=%h t=%h q=%b",
                 m_o, n_o, t_o, ser_q_o, em, en, et, esh[13]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    sd = b; tick(3);
    sc = 1'b1; tick(4);
    sc = 1'b0; tick(4);
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    check("R1 m", m_o, 9'h1FF);
    check("R1 n", n_o, 2'b11);
    check("R1 t", t_o, 3'b000);
    check("R1 q", ser_q_o, 0);

    // R9 latency, R6 follow
    pl = 1'b0; pm = 9'h0A5; pn = 2'b01;
    tick(2);
    check("R9 not yet", m_o, 9'h1FF);
    tick(1);
    check("R9 third edge", m_o, 9'h0A5);
    check("R6 n follows", n_o, 2'b01);
    check("R6 t zero", t_o, 0);
    pm = 9'h15A; tick(5);
    check("R6 m follows", m_o, 9'h15A);

    // R7 capture on rising strobe
    pl = 1'b1; tick(5);
    pm = 9'h003; pn = 2'b10; tick(5);
    check("R7 m held", m_o, 9'h15A);
    check("R7 n held", n_o, 2'b01);

    // R3, R4, R10
    send_word({3'b101, 2'b10, 9'h133});
    check("R3 msb out", ser_q_o, 1);
    check("R10 m unchanged", m_o, 9'h15A);
    sl = 1'b1; tick(5); sl = 1'b0; tick(5);
    check("R4 m field", m_o, 9'h133);
    check("R4 n field", n_o, 2'b10);
    check("R4 t field", t_o, 3'b101);

    // R5 transparency then freeze, R2 single step
    sl = 1'b1; tick(5);
    send_bit(1'b0);
    check("R2 one step", ser_q_o, 0);
    check("R5 follow m", m_o, 9'h066);
    check("R5 follow t", t_o, 3'b011);
    sl = 1'b0; tick(5);
    send_bit(1'b1);
    check("R2 next step", ser_q_o, 1);
    check("R5 frozen m", m_o, 9'h066);
    check("R10 n unchanged", n_o, 2'b01);

    // R8 parallel priority over serial strobe
    pm = 9'h0AA; pn = 2'b00; pl = 1'b0; tick(2);
    sl = 1'b1; tick(6);
    check("R8 m from pins", m_o, 9'h0AA);
    check("R8 t zero", t_o, 0);
    sl = 1'b0; tick(4);
    pl = 1'b1; tick(5);
    pm = 9'h111; tick(5);
    check("R7 m kept", m_o, 9'h0AA);
    check("R8 n from pins", n_o, 2'b00);

    tick(4);
    finish_run();
  end
endmodule